// File: doc/BRIEF.md
# Blitter Command Queue Front-End

This block sits between a host that speaks a narrow 16-bit register bus and a 2D drawing engine. The host builds each 32-bit accelerator command from two register writes, upper half first, and the second write pushes the assembled word into a command queue. The host polls a pending-count register to learn how much room is left before it writes a batch.

The block pops queued words in order and decodes the top byte. Parameter opcodes load a bank of shadow registers that the engine reads through a select port. Launch opcodes hand a start pulse, a kind code and sixteen flag bits to the engine, but only when the engine is idle. Because the queue is strictly ordered, every parameter queued before a launch is in place when that launch starts. The engine reports completion with a one-cycle done pulse. Completion raises a sticky status bit that software clears by writing 1, and an enable bit gates the interrupt line. A clear register empties the queue. A push into a full queue is dropped and recorded in a sticky overflow bit.

Top module: `blit_cmdq`

## Requirements
- R1: A write to address 0 only holds the upper 16 bits and queues nothing. A write to address 1 pushes {held upper half, written lower half} as one command word.
- R2: An opcode from 0x00 to 0x17 in bits 31:24 loads shadow register number opcode from bits 23:0, masked as follows. Register 0 keeps bits 20:1. Registers 3, 8, 12 and 13 keep bits 23:1. Register 9 keeps bits 7:0. Registers 10, 11 and 18 to 23 keep bits 15:0. All others keep bits 9:0. The register is readable on `prm_val` when `prm_sel` selects it.
- R3: An opcode from 0x20 to 0x24 is dispatched only while the engine is idle. Dispatch is a one-cycle `eng_go` with `eng_kind` = opcode − 0x20 and `eng_flags` = bits 15:0. Commands take effect in queue order.
- R4: A read of address 2 returns the number of queued words that have not yet been consumed.
- R5: A push into a full queue (DEPTH words) is dropped, the count stays at DEPTH, and bit 1 of address 4 is set. That bit stays set until 1 is written to it.
- R6: Bit 1 of address 3 reads 1 from the dispatch of a launch until the engine's done pulse.
- R7: A done pulse sets bit 0 of address 4, and writing 1 to that bit clears it. `irq` is high exactly when that bit and bit 0 of address 5 (enable) are both 1.
- R8: Writing a value with bit 0 set to address 6 discards every queued word. Writing 0 there has no effect.
- R9: Opcodes outside both ranges are consumed and have no effect on the shadow registers or the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| eng_done | input | 1 | Engine completion pulse |
| eng_go | output | 1 | Launch start pulse |
| eng_kind | output | 3 | Launch kind (opcode − 0x20) |
| eng_flags | output | 16 | Launch flag bits |
| prm_sel | input | 5 | Shadow register select |
| prm_val | output | 24 | Selected shadow register value |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the queue with DEPTH = 8, which leaves the DEPTH parameter as the only change from the default build. With that depth, one blocked launch followed by a short run of pushes reaches a full queue and then overflow. The bench checks the count after every push, so the whole range from empty to saturated is covered. All 24 shadow registers are swept with a mask computed independently in the bench.

// File: rtl/blit_cmdq_pkg.sv
package blit_cmdq_pkg;
  localparam int PRM_W  = 24;
  localparam int NPARAM = 24;
  localparam logic [7:0] OP_PRM_LAST = 8'h17;
  localparam logic [7:0] OP_GO_FIRST = 8'h20;
  localparam logic [7:0] OP_GO_LAST  = 8'h24;

  typedef enum logic [2:0] {
    RA_HI = 3'd0, RA_LO = 3'd1, RA_COUNT = 3'd2, RA_EXEC = 3'd3,
    RA_IRQ = 3'd4, RA_IEN = 3'd5, RA_CLR = 3'd6
  } reg_addr_e;

  // keep-mask for each shadow register
  function automatic logic [PRM_W-1:0] param_mask(input logic [4:0] idx);
    case (idx)
      5'd0:                     param_mask = 24'h1FFFFE;
      5'd3, 5'd8, 5'd12, 5'd13: param_mask = 24'hFFFFFE;
      5'd9:                     param_mask = 24'h0000FF;
      5'd10, 5'd11, 5'd18, 5'd19, 5'd20, 5'd21, 5'd22, 5'd23:
                                param_mask = 24'h00FFFF;
      default:                  param_mask = 24'h0003FF;
    endcase
  endfunction

  function automatic logic is_launch(input logic [7:0] op);
    is_launch = (op >= OP_GO_FIRST) && (op <= OP_GO_LAST);
  endfunction
endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int DEPTH = 512,
  parameter int W     = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    adv = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_push) wp <= adv(wp);
      if (do_pop)  rp <= adv(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/cmdq_params.sv
module cmdq_params
  import blit_cmdq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [4:0]       widx,
  input  logic [PRM_W-1:0] wdata,
  input  logic [4:0]       rsel,
  output logic [PRM_W-1:0] rdata
);
  logic [PRM_W-1:0] bank [NPARAM];

  for (genvar i = 0; i < NPARAM; i++) begin : g_prm
    always_ff @(posedge clk) begin
      if (!rst_n) bank[i] <= '0;
      else if (we && widx == 5'(i)) bank[i] <= wdata & param_mask(5'(i));
    end
  end

  assign rdata = (int'(rsel) < NPARAM) ? bank[rsel] : '0;
endmodule

// File: rtl/blit_cmdq.sv
module blit_cmdq
  import blit_cmdq_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        eng_done,
  output logic        eng_go,
  output logic [2:0]  eng_kind,
  output logic [15:0] eng_flags,
  input  logic [4:0]  prm_sel,
  output logic [23:0] prm_val,
  output logic        irq
);
  logic [15:0]   hi_q;
  logic [31:0]   head;
  logic [CW-1:0] q_count;
  logic          q_full, q_empty;
  logic          busy_q, done_st, ovf_st, ien_q;

  // named events for the assertions
  wire wr_hi   = reg_we && reg_addr == RA_HI;
  wire wr_lo   = reg_we && reg_addr == RA_LO;
  wire wr_irq  = reg_we && reg_addr == RA_IRQ;
  wire wr_ien  = reg_we && reg_addr == RA_IEN;
  wire wr_clr  = reg_we && reg_addr == RA_CLR && reg_wdata[0];
  wire push_ok = wr_lo && !wr_clr && !q_full;
  wire push_drop = wr_lo && !wr_clr && q_full;

  wire [7:0] head_op  = head[31:24];
  wire head_go  = is_launch(head_op);
  wire pop      = !q_empty && !wr_clr && (!head_go || !busy_q);
  wire launch_fire = pop && head_go;
  wire param_we    = pop && head_op <= OP_PRM_LAST;
  wire done_evt    = eng_done && busy_q;

  cmdq_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(wr_clr), .push(push_ok), .pop(pop),
    .din({hi_q, reg_wdata}), .dout(head), .count(q_count),
    .full(q_full), .empty(q_empty));

  cmdq_params u_prm (
    .clk(clk), .rst_n(rst_n), .we(param_we), .widx(head_op[4:0]),
    .wdata(head[23:0]), .rsel(prm_sel), .rdata(prm_val));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q <= '0; busy_q <= 1'b0; done_st <= 1'b0; ovf_st <= 1'b0;
      ien_q <= 1'b0; eng_go <= 1'b0; eng_kind <= '0; eng_flags <= '0;
    end else begin
      if (wr_hi) hi_q <= reg_wdata;
      if (wr_ien) ien_q <= reg_wdata[0];
      eng_go <= launch_fire;
      if (launch_fire) begin
        eng_kind  <= 3'(head_op - OP_GO_FIRST);
        eng_flags <= head[15:0];
        busy_q    <= 1'b1;
      end else if (eng_done) begin
        busy_q <= 1'b0;
      end
      if (done_evt) done_st <= 1'b1;
      else if (wr_irq && reg_wdata[0]) done_st <= 1'b0;
      if (push_drop) ovf_st <= 1'b1;
      else if (wr_irq && reg_wdata[1]) ovf_st <= 1'b0;
    end
  end

  assign irq = done_st && ien_q;

  always_comb begin
    case (reg_addr)
      RA_COUNT: reg_rdata = 16'(q_count);
      RA_EXEC:  reg_rdata = {14'd0, busy_q, 1'b0};
      RA_IRQ:   reg_rdata = {14'd0, ovf_st, done_st};
      RA_IEN:   reg_rdata = {15'd0, ien_q};
      default:  reg_rdata = '0;
    endcase
  end

  a_r3_fire_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    launch_fire |-> !busy_q);
  a_r3_go_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |=> !eng_go);
  a_r5_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> ovf_st);
  a_r7_done_from_engine: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_st) |-> $past(eng_done));
  a_r6_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go |-> busy_q);
endmodule

// File: tb/blit_cmdq_test.sv
`timescale 1ns/1ps
module blit_cmdq_test;
  localparam int DEPTH = 8;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata; logic eng_done = 0, eng_go, irq;
  logic [2:0] eng_kind; logic [15:0] eng_flags;
  logic [4:0] prm_sel = 0; logic [23:0] prm_val;
  int n_run = 0, n_fail = 0, go_cnt = 0;
  logic [2:0] last_kind; logic [15:0] last_flags; logic [23:0] prm_at_go;

  always #4 clk = ~clk;

  blit_cmdq #(.DEPTH(DEPTH)) uut (.*);

  always @(posedge clk) if (eng_go) begin
    go_cnt++; last_kind <= eng_kind; last_flags <= eng_flags; prm_at_go <= prm_val;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_addr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    wr(3'd0, w[31:16]); wr(3'd1, w[15:0]);
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1; @(negedge clk); eng_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [23:0] exp_mask(input int op);
    if (op == 0) return 24'h1FFFFE;
    if (op == 3 || op == 8 || op == 12 || op == 13) return 24'hFFFFFE;
    if (op == 9) return 24'h0000FF;
    if (op == 10 || op == 11 || op >= 18) return 24'h00FFFF;
    return 24'h0003FF;
  endfunction

  task automatic prm(input int i, output int v);
    @(negedge clk); prm_sel = 5'(i); #1 v = prm_val;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v, g0;
    idle(3); rst_n = 1; idle(1);
    // reset state
    rd(3'd2, v); check("R4 reset count", v, 0);
    rd(3'd3, v); check("R6 reset busy", v, 0);
    rd(3'd4, v); check("R7 reset status", v, 0);
    check("R7 reset irq", irq, 0);

    // R1: high half alone queues nothing
    wr(3'd0, 16'h0401); idle(3);
    rd(3'd2, v); check("R1 hi-only count", v, 0);
    prm(4, v); check("R1 hi-only param", v, 0);
    wr(3'd1, 16'h0155); idle(3);
    prm(4, v); check("R1 assembled param", v, 24'h155 & exp_mask(4));

    // R2: sweep all shadow registers
    for (int i = 0; i < 24; i++) push({8'(i), 24'hABCDEF ^ (24'(i) * 24'h010101)});
    idle(3);
    for (int i = 0; i < 24; i++) begin
      prm(i, v);
      check($sformatf("R2 mask reg %0d", i), v,
            (24'hABCDEF ^ (24'(i) * 24'h010101)) & exp_mask(i));
    end

    // R9: unknown opcodes
    prm(0, g0);
    push(32'h18FFFFFF); push(32'h1F123456); push(32'h25ABCDEF); push(32'hFF000001);
    idle(3);
    prm(0, v); check("R9 unknown no param", v, g0);
    check("R9 unknown no go", go_cnt, 0);
    rd(3'd2, v); check("R9 consumed count", v, 0);

    // R3/R6/R7: launch with a preceding parameter
    prm_sel = 5'd11;
    push(32'h0B00BEEF); push(32'h22001234); idle(3);
    check("R3 go count", go_cnt, 1);
    check("R3 kind", last_kind, 2);
    check("R3 flags", last_flags, 16'h1234);
    check("R3 param before launch", prm_at_go, 24'h00BEEF);
    rd(3'd3, v); check("R6 busy set", v, 2);
    done_pulse(); idle(1);
    rd(3'd3, v); check("R6 busy cleared", v, 0);
    rd(3'd4, v); check("R7 done status", v, 1);
    check("R7 irq masked", irq, 0);
    wr(3'd5, 16'h1); #1 check("R7 irq enabled", irq, 1);
    wr(3'd4, 16'h1); #1 check("R7 irq after w1c", irq, 0);
    rd(3'd4, v); check("R7 status after w1c", v, 0);

    // R4/R5: fill with a blocked launch
    push(32'h20000001); idle(2);
    check("R3 first launch", go_cnt, 2);
    push(32'h2400ABCD);
    rd(3'd2, v); check("R4 count 1", v, 1);
    for (int k = 2; k <= DEPTH; k++) begin
      push({8'h05, 24'(k)});
      rd(3'd2, v); check($sformatf("R4 count %0d", k), v, k);
    end
    push({8'h05, 24'd99});
    rd(3'd2, v); check("R5 count saturated", v, DEPTH);
    rd(3'd4, v); check("R5 overflow flag", v, 2);
    check("R3 blocked while busy", go_cnt, 2);
    done_pulse(); idle(DEPTH + 3);
    check("R3 queued launch", go_cnt, 3);
    check("R3 queued kind", last_kind, 4);
    prm(5, v); check("R5 dropped word not applied", v, DEPTH);
    rd(3'd4, v); check("R5 overflow sticky", v & 2, 2);
    wr(3'd4, 16'h2);
    rd(3'd4, v); check("R5 overflow w1c", v & 2, 0);

    // R8: clear
    push(32'h21000000); push(32'h05000033); push(32'h05000044);
    rd(3'd2, v); check("R8 count before", v, 3);
    wr(3'd6, 16'h0);
    rd(3'd2, v); check("R8 write 0 no effect", v, 3);
    wr(3'd6, 16'h1);
    rd(3'd2, v); check("R8 cleared", v, 0);
    done_pulse(); idle(4);
    check("R8 no launch after clear", go_cnt, 3);
    prm(5, v); check("R8 params kept", v, DEPTH);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule